// File: doc/BRIEF.md
# Radix-8 Interleaved Modular Multiplier for the 2^255−19 Field

This block forms the product of two 255-bit operands reduced modulo the prime p = 2^255−19, using only adders, comparators and small constant multiples. There is no wide integer multiplier. The multiplier operand is consumed three bits per clock, starting from its top end. Each three-bit digit selects one of eight precomputed multiples of the multiplicand. A running total is kept as a sum/carry pair, so no long carry chain sits in the loop.

Whenever the running total grows past bit 255, the excess is folded back through a small residue term on the following step, in place of a comparison against p. The multiples of the multiplicand are built during a fixed warm-up phase with one modular adder. When the digit loop ends, one reduction stage turns the redundant pair into a canonical residue.

A caller drives the two operands with a one-cycle start pulse and waits for done. Only one operation runs at a time. The latency is fixed and does not depend on the operand values.

Top module: `radix8_modmul`

## Requirements
- R1: `result` equals (op_x · op_y) mod p, with p = 2^255−19, and always lies in [0, p) for any pair of 255-bit operands.
- R2: `done` is high for exactly one cycle. That cycle directly follows the 96th rising clock edge after the edge that accepted `start` (10 warm-up edges, 85 digit edges, 1 reduction edge).
- R3: A `start` seen while an operation is in progress is ignored. It affects neither the result nor the timing of the running operation.
- R4: `result` changes only in the cycle in which `done` is high, and holds its value at all other times.
- R5: While `rst_n` is low, and after it is released with no operation started, `done` is 0 and `result` is 0.
- R6: The operands are captured on the accepting edge. Later changes of `op_x` or `op_y` have no effect on the running operation.
- R7: Corner operands give exact residues: 0·Y = 0, 1·Y = Y mod p, and (p−1)·(p−1) = 1.
- R8: Operands at or above p are handled. p·Y = 0, and (2^255−1)·(2^255−1) = 324, because 2^255−1 ≡ 18.
- R9: `start` is accepted again on the edge that follows the edge raising `done`. Holding `start` high therefore gives back-to-back operations, with `done` pulses 97 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| op_x | input | 255 | Multiplier operand, scanned in 3-bit digits from the top |
| op_y | input | 255 | Multiplicand operand, expanded into the multiples table |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | 255 | Fully reduced product, held until the next `done` |

## Verification
Every product is due in the cycle after the 96th rising edge following the accepting edge, and it stays in place until the next pulse. The bench keeps its own count of edges from each accepted start and of the pending wide-integer product. At every falling edge it compares `done` and `result` with that model. Each scenario also counts the falling edges from acceptance to the pulse, so a pulse that is one cycle early or late is reported directly. For a start ignored mid-run, and for a start held high across a pulse, the model follows the same acceptance rule, so the next expected pulse moves only when a start is really taken.

// File: rtl/r8mm_pkg.sv
package r8mm_pkg;
  localparam int unsigned DEF_FIELD_W  = 255;
  localparam int unsigned DEF_FOLD_C   = 19;
  localparam int unsigned DEF_DIGIT_W  = 3;
  localparam int unsigned DEF_WARM_CYC = 10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WARM = 2'd1,
    ST_RUN  = 2'd2,
    ST_FIN  = 2'd3
  } r8mm_state_e;
endpackage

// File: rtl/r8mm_ctrl.sv
module r8mm_ctrl #(
  parameter int unsigned WARM_CYC = r8mm_pkg::DEF_WARM_CYC,
  parameter int unsigned ITERS    = 85,
  parameter int unsigned CNT_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             op_load,
  output logic             fill_en,
  output logic             run_step,
  output logic             finish,
  output logic [CNT_W-1:0] phase_cnt
);
  import r8mm_pkg::*;

  r8mm_state_e state_q;
  logic [CNT_W-1:0] cnt_q;

  wire warm_last = (cnt_q == CNT_W'(WARM_CYC - 1));
  wire run_last  = (cnt_q == CNT_W'(ITERS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_WARM;
            cnt_q   <= '0;
          end
        end
        ST_WARM: begin
          if (warm_last) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RUN: begin
          if (run_last) begin
            state_q <= ST_FIN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_FIN: begin
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign op_load   = start && (state_q == ST_IDLE);
  assign fill_en   = (state_q == ST_WARM);
  assign run_step  = (state_q == ST_RUN);
  assign finish    = (state_q == ST_FIN);
  assign phase_cnt = cnt_q;
endmodule

// File: rtl/r8mm_mult_table.sv
module r8mm_mult_table #(
  parameter int unsigned FIELD_W = r8mm_pkg::DEF_FIELD_W,
  parameter int unsigned FOLD_C  = r8mm_pkg::DEF_FOLD_C,
  parameter int unsigned DIGIT_W = r8mm_pkg::DEF_DIGIT_W,
  parameter int unsigned CNT_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_y,
  input  logic [FIELD_W-1:0] y_in,
  input  logic               fill_en,
  input  logic [CNT_W-1:0]   fill_idx,
  input  logic [DIGIT_W-1:0] digit,
  output logic [FIELD_W-1:0] mult
);
  localparam int unsigned NMULT = 1 << DIGIT_W;
  localparam logic [FIELD_W-1:0] PRIME = {FIELD_W{1'b1}} - FIELD_W'(FOLD_C - 1);

  // One conditional subtraction: valid for any value below 2^FIELD_W
  function automatic logic [FIELD_W-1:0] reduce_once(input logic [FIELD_W-1:0] v);
    return (v >= PRIME) ? (v - PRIME) : v;
  endfunction

  // Sum of two residues, brought back below p
  function automatic logic [FIELD_W-1:0] mod_add(input logic [FIELD_W-1:0] a,
                                                 input logic [FIELD_W-1:0] b);
    logic [FIELD_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, PRIME}) s = s - {1'b0, PRIME};
    return s[FIELD_W-1:0];
  endfunction

  logic [FIELD_W-1:0] y_q;
  logic [FIELD_W-1:0] ent [NMULT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      y_q <= '0;
    else if (load_y) y_q <= y_in;
  end

  assign ent[0] = '0;

  // Entry g holds g*Y mod p; entry g is written on warm-up step g-1
  for (genvar g = 1; g < NMULT; g++) begin : g_row
    logic [FIELD_W-1:0] val_q;
    logic [FIELD_W-1:0] val_d;
    if (g == 1) begin : g_base
      assign val_d = reduce_once(y_q);
    end else begin : g_chain
      assign val_d = mod_add(ent[g-1], ent[1]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     val_q <= '0;
      else if (fill_en && (fill_idx == CNT_W'(g - 1))) val_q <= val_d;
    end
    assign ent[g] = val_q;
  end

  assign mult = ent[digit];
endmodule

// File: rtl/r8mm_csa_acc.sv
module r8mm_csa_acc #(
  parameter int unsigned FIELD_W = r8mm_pkg::DEF_FIELD_W,
  parameter int unsigned FOLD_C  = r8mm_pkg::DEF_FOLD_C,
  parameter int unsigned DIGIT_W = r8mm_pkg::DEF_DIGIT_W,
  parameter int unsigned ACC_W   = FIELD_W + DIGIT_W + 2,
  parameter int unsigned IDX_W   = ACC_W - FIELD_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               step,
  input  logic [FIELD_W-1:0] mult,
  output logic [ACC_W-1:0]   acc_s,
  output logic [ACC_W-1:0]   acc_c,
  output logic [IDX_W-1:0]   fold_idx
);
  localparam int unsigned HI_W = ACC_W - FIELD_W;
  // Residue of 2^(FIELD_W+DIGIT_W) modulo p
  localparam logic [ACC_W-1:0] FOLD_UNIT = ACC_W'(FOLD_C * (1 << DIGIT_W));

  function automatic logic [ACC_W-1:0] csa_sum(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] b,
                                               input logic [ACC_W-1:0] c);
    return a ^ b ^ c;
  endfunction

  function automatic logic [ACC_W-1:0] csa_carry(input logic [ACC_W-1:0] a,
                                                 input logic [ACC_W-1:0] b,
                                                 input logic [ACC_W-1:0] c);
    return ((a & b) | (a & c) | (b & c)) << 1;
  endfunction

  // Residue standing in for the dropped high bits after the next shift
  function automatic logic [ACC_W-1:0] fold_term(input logic [IDX_W-1:0] k);
    return ACC_W'(k) * FOLD_UNIT;
  endfunction

  logic [ACC_W-1:0] s_q, c_q;
  logic [ACC_W-1:0] s_sh, c_sh, m_ext, corr;
  logic [ACC_W-1:0] ps, pc, ns, nc;

  always_comb begin
    fold_idx = IDX_W'(s_q[ACC_W-1:FIELD_W]) + IDX_W'(c_q[ACC_W-1:FIELD_W]);
    corr     = fold_term(fold_idx);
    s_sh     = ACC_W'({s_q[FIELD_W-1:0], {DIGIT_W{1'b0}}});
    c_sh     = ACC_W'({c_q[FIELD_W-1:0], {DIGIT_W{1'b0}}});
    m_ext    = ACC_W'(mult);
    ps       = csa_sum(s_sh, c_sh, m_ext);
    pc       = csa_carry(s_sh, c_sh, m_ext);
    ns       = csa_sum(ps, pc, corr);
    nc       = csa_carry(ps, pc, corr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= '0;
      c_q <= '0;
    end else if (clear) begin
      s_q <= '0;
      c_q <= '0;
    end else if (step) begin
      s_q <= ns;
      c_q <= nc;
    end
  end

  assign acc_s = s_q;
  assign acc_c = c_q;

  logic unused_hi;
  assign unused_hi = ^{HI_W{1'b0}};
endmodule

// File: rtl/r8mm_reducer.sv
module r8mm_reducer #(
  parameter int unsigned FIELD_W = r8mm_pkg::DEF_FIELD_W,
  parameter int unsigned FOLD_C  = r8mm_pkg::DEF_FOLD_C,
  parameter int unsigned ACC_W   = FIELD_W + 5
) (
  input  logic [ACC_W-1:0]   red_s,
  input  logic [ACC_W-1:0]   red_c,
  output logic [FIELD_W-1:0] red_out
);
  localparam int unsigned TOP_W = ACC_W + 1 - FIELD_W;
  localparam logic [FIELD_W-1:0] PRIME = {FIELD_W{1'b1}} - FIELD_W'(FOLD_C - 1);

  // Resolve the pair, fold bits above 2^FIELD_W by their residue, subtract p once
  function automatic logic [FIELD_W-1:0] full_reduce(input logic [ACC_W-1:0] s,
                                                     input logic [ACC_W-1:0] c);
    logic [ACC_W:0]   tot;
    logic [TOP_W-1:0] top;
    logic [FIELD_W:0] fold;
    tot  = {1'b0, s} + {1'b0, c};
    top  = tot[ACC_W:FIELD_W];
    fold = {1'b0, tot[FIELD_W-1:0]} + ((FIELD_W+1)'(top) * (FIELD_W+1)'(FOLD_C));
    if (fold >= {1'b0, PRIME}) fold = fold - {1'b0, PRIME};
    return fold[FIELD_W-1:0];
  endfunction

  assign red_out = full_reduce(red_s, red_c);
endmodule

// File: rtl/radix8_modmul.sv
module radix8_modmul #(
  parameter int unsigned FIELD_W  = r8mm_pkg::DEF_FIELD_W,
  parameter int unsigned FOLD_C   = r8mm_pkg::DEF_FOLD_C,
  parameter int unsigned DIGIT_W  = r8mm_pkg::DEF_DIGIT_W,
  parameter int unsigned WARM_CYC = r8mm_pkg::DEF_WARM_CYC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FIELD_W-1:0] op_x,
  input  logic [FIELD_W-1:0] op_y,
  output logic               done,
  output logic [FIELD_W-1:0] result
);
  // FIELD_W must be a multiple of DIGIT_W; WARM_CYC must be at least 2^DIGIT_W - 1
  localparam int unsigned ITERS = FIELD_W / DIGIT_W;
  localparam int unsigned ACC_W = FIELD_W + DIGIT_W + 2;
  localparam int unsigned IDX_W = ACC_W - FIELD_W + 1;
  localparam int unsigned CNT_W = $clog2(((WARM_CYC > ITERS) ? WARM_CYC : ITERS) + 1);

  logic               busy, op_load, fill_en, run_step, finish;
  logic [CNT_W-1:0]   phase_cnt;
  logic [FIELD_W-1:0] x_q;
  logic [DIGIT_W-1:0] digit;
  logic [FIELD_W-1:0] mult;
  logic [ACC_W-1:0]   acc_s, acc_c;
  logic [IDX_W-1:0]   fold_idx;
  logic [FIELD_W-1:0] red_out;

  r8mm_ctrl #(
    .WARM_CYC(WARM_CYC), .ITERS(ITERS), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .op_load(op_load), .fill_en(fill_en),
    .run_step(run_step), .finish(finish), .phase_cnt(phase_cnt)
  );

  // Multiplier digits leave from the top of a shift register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        x_q <= '0;
    else if (op_load)  x_q <= op_x;
    else if (run_step) x_q <= {x_q[FIELD_W-DIGIT_W-1:0], {DIGIT_W{1'b0}}};
  end
  assign digit = x_q[FIELD_W-1 -: DIGIT_W];

  r8mm_mult_table #(
    .FIELD_W(FIELD_W), .FOLD_C(FOLD_C), .DIGIT_W(DIGIT_W), .CNT_W(CNT_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .load_y(op_load), .y_in(op_y),
    .fill_en(fill_en), .fill_idx(phase_cnt), .digit(digit), .mult(mult)
  );

  r8mm_csa_acc #(
    .FIELD_W(FIELD_W), .FOLD_C(FOLD_C), .DIGIT_W(DIGIT_W),
    .ACC_W(ACC_W), .IDX_W(IDX_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(op_load), .step(run_step), .mult(mult),
    .acc_s(acc_s), .acc_c(acc_c), .fold_idx(fold_idx)
  );

  r8mm_reducer #(
    .FIELD_W(FIELD_W), .FOLD_C(FOLD_C), .ACC_W(ACC_W)
  ) u_reduce (
    .red_s(acc_s), .red_c(acc_c), .red_out(red_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= finish;
      if (finish) result <= red_out;
    end
  end
endmodule

// File: rtl/r8mm_checker.sv
module r8mm_checker #(
  parameter int unsigned FIELD_W  = 255,
  parameter int unsigned FOLD_C   = 19,
  parameter int unsigned DIGIT_W  = 3,
  parameter int unsigned WARM_CYC = 10,
  parameter int unsigned ITERS    = 85,
  parameter int unsigned IDX_W    = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               done,
  input logic [FIELD_W-1:0] result,
  input logic               busy,
  input logic               op_load,
  input logic               finish,
  input logic               run_step,
  input logic [IDX_W-1:0]   fold_idx
);
  localparam logic [FIELD_W-1:0] PRIME = {FIELD_W{1'b1}} - FIELD_W'(FOLD_C - 1);
  localparam int unsigned DONE_AT  = WARM_CYC + ITERS + 2;
  localparam int unsigned FOLD_MAX = 1 << (DIGIT_W + 1);
  localparam int unsigned SW = $clog2(DONE_AT + 2) + 1;

  // Cycles elapsed since the accepting edge, saturating past the due point
  logic [SW-1:0] since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       since <= '0;
    else if (op_load)                                 since <= SW'(1);
    else if (since != '0 && since < SW'(DONE_AT + 1)) since <= since + 1'b1;
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (since == SW'(DONE_AT)));

  assert_done_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since == SW'(DONE_AT)) |-> done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !finish) |=> busy);

  assert_busy_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_result_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < PRIME));

  assert_fold_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run_step |-> (fold_idx <= IDX_W'(FOLD_MAX)));

  assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
endmodule

bind radix8_modmul r8mm_checker #(
  .FIELD_W(FIELD_W), .FOLD_C(FOLD_C), .DIGIT_W(DIGIT_W),
  .WARM_CYC(WARM_CYC), .ITERS(ITERS), .IDX_W(IDX_W)
) u_r8mm_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .result(result),
  .busy(busy), .op_load(op_load), .finish(finish), .run_step(run_step),
  .fold_idx(fold_idx)
);

// File: tb/radix8_modmul_bench.sv
module radix8_modmul_bench;
  localparam int W    = 255;
  localparam int LAT  = 96;
  localparam int WDOG = 40000;
  localparam logic [W-1:0] P = {W{1'b1}} - W'(18);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] x_in = '0;
  logic [W-1:0] y_in = '0;
  logic         done;
  logic [W-1:0] result;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  bit compare_on = 1'b0;

  always #4 clk = ~clk;

  radix8_modmul u_radix8_modmul (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_x(x_in), .op_y(y_in), .done(done), .result(result)
  );

  function automatic logic [W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] pr;
    pr = (2*W)'(a) * (2*W)'(b);
    return W'(pr % (2*W)'(P));
  endfunction

  function automatic logic [W-1:0] rnd255();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom();
    return v[W-1:0];
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural model: pending product and edge count since acceptance
  bit           m_busy = 1'b0;
  int           m_cnt = 0;
  logic [W-1:0] m_pend = '0;
  bit           m_done = 1'b0;
  logic [W-1:0] m_res = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_cnt <= 0; m_done <= 1'b0; m_res <= '0; m_pend <= '0;
    end else begin
      m_done <= 1'b0;
      if (m_busy) begin
        if (m_cnt == LAT - 1) begin
          m_busy <= 1'b0;
          m_done <= 1'b1;
          m_res  <= m_pend;
        end
        m_cnt <= m_cnt + 1;
      end else if (start) begin
        m_busy <= 1'b1;
        m_cnt  <= 0;
        m_pend <= ref_mul(x_in, y_in);
      end
    end
  end

  // Every-cycle comparison against the model (R2 timing, R4 hold)
  always @(negedge clk) begin
    if (compare_on && !finished) begin
      check(done == m_done, "R2 done vs model", W'(done), W'(m_done));
      check(result == m_res, "R4 result vs model", result, m_res);
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Operands are replaced by junk right after acceptance (R6)
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    x_in = a; y_in = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; x_in = rnd255(); y_in = rnd255();
  endtask

  // Returns the number of rising edges from acceptance to the done cycle
  task automatic wait_done(output int edges);
    int n;
    n = 1;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    edges = n - 1;
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    int edges;
    issue(a, b);
    wait_done(edges);
    check(result == ref_mul(a, b), tag, result, ref_mul(a, b));
    check(edges == LAT, "R2 latency", W'(edges), W'(LAT));
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WDOG);
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] a, b, c, d;
    int edges;
    // R5: reset state
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R5 done in reset", W'(done), '0);
    check(result == '0, "R5 result in reset", result, '0);
    rst_n = 1'b1;
    compare_on = 1'b1;
    repeat (4) @(negedge clk);
    check(done == 1'b0, "R5 done after reset", W'(done), '0);
    check(result == '0, "R5 result after reset", result, '0);

    // R7: corner operands
    a = rnd255();
    run_op('0, a, "R7 zero times Y");
    check(result == '0, "R7 zero literal", result, '0);
    run_op(W'(1), a, "R7 one times Y");
    run_op(P - 1'b1, P - 1'b1, "R7 (p-1)^2");
    check(result == W'(1), "R7 (p-1)^2 literal", result, W'(1));

    // R8: operands at or above p
    run_op('1, '1, "R8 all-ones squared");
    check(result == W'(324), "R8 all-ones literal", result, W'(324));
    run_op(P, rnd255(), "R8 p times Y");
    check(result == '0, "R8 p literal", result, '0);
    run_op(rnd255(), P + W'(5), "R8 Y above p");

    // R6: operand inputs change right after acceptance
    run_op(rnd255(), rnd255(), "R6 operands captured");

    // R1: random operands
    for (int i = 0; i < 6; i++) run_op(rnd255(), rnd255(), "R1 random product");

    // R3: a second start in mid-run is ignored
    a = rnd255(); b = rnd255(); c = rnd255(); d = rnd255();
    issue(a, b);
    repeat (19) @(negedge clk);
    x_in = c; y_in = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 20;
    while (!done && edges < 400) begin
      @(negedge clk);
      edges++;
    end
    check(result == ref_mul(a, b), "R3 busy start ignored", result, ref_mul(a, b));
    check(edges == LAT, "R3 timing unchanged", W'(edges), W'(LAT));
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R3 no second done", W'(done), '0);

    // R9: start held high gives back-to-back operations
    a = rnd255(); b = rnd255(); c = rnd255(); d = rnd255();
    @(negedge clk);
    x_in = a; y_in = b; start = 1'b1;
    @(negedge clk);
    wait_done(edges);
    check(result == ref_mul(a, b), "R9 first of pair", result, ref_mul(a, b));
    x_in = c; y_in = d;
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    while (!done && edges < 400) begin
      @(negedge clk);
      edges++;
    end
    check(result == ref_mul(c, d), "R9 second of pair", result, ref_mul(c, d));
    check(edges == LAT + 1, "R9 pulse spacing", W'(edges), W'(LAT + 1));

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule